// File: doc/BRIEF.md
# Masked-write open-drain pad control register

This block is a 32-bit control word for two open-drain pads, a clock line and a data line, that software toggles directly to bit-bang an I2C-style two-wire bus. Each pad owns one 8-bit lane of the word. A lane holds a direction flag, an output value, a pull-up-disable flag and a read-only sampled copy of the line level. Two write-enable bits travel with every write and are never stored.

The direction and value of a pad change only when a write carries that field's enable bit. Software can therefore flip one pad, or one field of a pad, with a single write and no read-modify-write. The pad is pulled low only while it is an output holding value 0. In every other state the pad is released and an external resistor pulls the line high. The pull-up-disable flags have no enable bit, so each write replaces them.

Each line level passes through a two-stage synchronizer before it appears in the word. The read word is registered.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, no pad is driven low and no pull-up is disabled. With both lines idle high, the read word is 0x0000_2020, meaning both input bits are 1 and every other bit is 0.
- R2: Lane p sits at bits [8p+7:8p]. Pad 0 is the clock and pad 1 is the data line. A lane's direction bit (bit 2, 1 = output) takes the written value only when the same write sets that lane's direction-enable bit (bit 1). Otherwise it keeps its value.
- R3: A lane's value bit (bit 4) takes the written value only when the same write sets that lane's value-enable bit (bit 3). Otherwise it keeps its value.
- R4: A pad's drive-low output is 1 exactly when its direction is output and its value is 0. It changes on the clock edge that captures the write.
- R5: Every write loads each lane's pull-up-disable bit (bit 0) from the written data, whatever the enable bits. The result shows on the pull-up-disable outputs and in the read word.
- R6: Each lane's input bit (bit 5) shows the pad's line level. A level change reaches the read word on the third rising edge after it, and not on the second.
- R7: Writes to the input bits, the enable bits, bits 6 and 7 of each lane and bits 31:16 have no effect. All of these read as 0, except the input bits.
- R8: A write that sets one lane's enable bits leaves the other lane's direction and value unchanged.
- R9: A reset in the middle of operation releases a pad that is being driven low, and it clears the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 32 | Write word, with lane fields and enable bits |
| rd_data | output | 32 | Registered read word |
| pad_in | input | 2 | Line levels; bit 0 is the clock, bit 1 is data |
| pad_drive_low | output | 2 | 1 pulls the pad low; 0 releases it |
| pad_pullup_dis | output | 2 | 1 disables that pad's pull-up |

## Verification
The hardest case to reach from the ports is an input bit that disagrees with what the block itself drives: a released line held low by another device. The bench models each line as a wired-AND of the block's drive and a separate external pull-down. With that model it can hold the data line low while the pad is released, and count the edges until the read word shows the change. The bench also shows that the controls are independent: it sends writes with the enable bits clear but the direction and value fields set, and writes whose enable bits cover only the other lane.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int LANE_W   = 8;
  localparam int B_PUD    = 0;
  localparam int B_DIRWE  = 1;
  localparam int B_DIR    = 2;
  localparam int B_VALWE  = 3;
  localparam int B_VAL    = 4;
  localparam int B_IN     = 5;

  typedef struct packed {
    logic pud;
    logic dir;
    logic val;
  } pad_cfg_t;
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age_q;
      always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
      end
      // R6: line level reaches the synchronizer output two edges later
      assert_sync_delay_R6: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/pad_lane.sv
module pad_lane
  import gpio_pad_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  logic     wr_pud,
  input  logic     wr_dirwe,
  input  logic     wr_dir,
  input  logic     wr_valwe,
  input  logic     wr_val,
  output pad_cfg_t cfg_o,
  output logic     drive_low_o
);
  pad_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.pud = wr_pud;
      if (wr_dirwe) cfg_d.dir = wr_dir;
      if (wr_valwe) cfg_d.val = wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      drive_low_o <= 1'b0;
    end else begin
      cfg_q       <= cfg_d;
      drive_low_o <= cfg_d.dir & ~cfg_d.val;
    end
  end

  assign cfg_o = cfg_q;

  // R2: direction holds unless its enable bit rides along with the write
  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_dirwe) |=> $stable(cfg_q.dir));
  // R3: value holds unless its enable bit rides along with the write
  assert_val_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_valwe) |=> $stable(cfg_q.val));
  // R4: the pad is pulled low only when it is an output holding 0
  assert_drive_rule_R4: assert property (@(posedge clk) disable iff (rst)
    drive_low_o == (cfg_q.dir && !cfg_q.val));
  // R5: pull-up disable follows every write
  assert_pud_load_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cfg_q.pud == $past(wr_pud)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_PADS  = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_drive_low,
  output logic [NUM_PADS-1:0] pad_pullup_dis
);
  localparam int USED_W = NUM_PADS * LANE_W;

  pad_cfg_t [NUM_PADS-1:0] cfg;
  logic     [NUM_PADS-1:0] in_sync;
  logic     [DATA_W-1:0]   rd_next;
  logic                    unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  generate
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      pad_lane u_lane (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_pud      (wr_data[p*LANE_W + B_PUD]),
        .wr_dirwe    (wr_data[p*LANE_W + B_DIRWE]),
        .wr_dir      (wr_data[p*LANE_W + B_DIR]),
        .wr_valwe    (wr_data[p*LANE_W + B_VALWE]),
        .wr_val      (wr_data[p*LANE_W + B_VAL]),
        .cfg_o       (cfg[p]),
        .drive_low_o (pad_drive_low[p])
      );

      pad_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in[p]),
        .dout (in_sync[p])
      );

      assign pad_pullup_dis[p] = cfg[p].pud;
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      rd_next[p*LANE_W + B_PUD] = cfg[p].pud;
      rd_next[p*LANE_W + B_DIR] = cfg[p].dir;
      rd_next[p*LANE_W + B_VAL] = cfg[p].val;
      rd_next[p*LANE_W + B_IN]  = in_sync[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  generate
    if (USED_W < DATA_W) begin : g_upper_chk
      // R7: bits above the lanes always read as zero
      assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-1:USED_W] == '0);
    end
  endgenerate

  // R7: enable bits are never stored, so they always read back as zero
  assert_enables_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_DIRWE] == 1'b0) && (rd_data[B_VALWE] == 1'b0));
endmodule

// File: tb/gpio_pad_ctrl_tb_top.sv
module gpio_pad_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  pad_in;
  logic [1:0]  pad_drive_low;
  logic [1:0]  pad_pullup_dis;
  logic [1:0]  ext_low = 2'b00;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign pad_in = ~(pad_drive_low | ext_low);

  gpio_pad_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pad_in(pad_in), .pad_drive_low(pad_drive_low), .pad_pullup_dis(pad_pullup_dis)
  );

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; settle();
    chk32("R1 read word", rd_data, 32'h0000_2020);
    chk32("R1 drive", {30'd0, pad_drive_low}, 32'd0);
    chk32("R1 pullup", {30'd0, pad_pullup_dis}, 32'd0);
  endtask

  task automatic t_drive_clock_low();
    wr(32'h0000_000E);
    chk32("R4 drive low after edge", {30'd0, pad_drive_low}, 32'd1);
    settle();
    chk32("R2 clock output word", rd_data, 32'h0000_2004);
    wr(32'h0000_0002);
    chk32("R2 release", {30'd0, pad_drive_low}, 32'd0);
    settle();
    chk32("R2 released word", rd_data, 32'h0000_2020);
  endtask

  task automatic t_no_enable();
    wr(32'h0000_0404);
    settle();
    chk32("R2 no enable drive", {30'd0, pad_drive_low}, 32'd0);
    chk32("R2 no enable word", rd_data, 32'h0000_2020);
  endtask

  task automatic t_value_path();
    wr(32'h0000_1E00);
    settle();
    chk32("R4 output high not driven", {30'd0, pad_drive_low}, 32'd0);
    chk32("R3 value set word", rd_data, 32'h0000_3420);
    wr(32'h0000_0800);
    chk32("R3 value cleared drives", {30'd0, pad_drive_low}, 32'd2);
    settle();
    chk32("R3 data low word", rd_data, 32'h0000_0420);
    wr(32'h0000_000A);
    settle();
    chk32("R8 other lane untouched", rd_data, 32'h0000_0420);
    chk32("R8 drive untouched", {30'd0, pad_drive_low}, 32'd2);
    wr(32'h0000_0200);
    settle();
    chk32("R2 data released", rd_data, 32'h0000_2020);
  endtask

  task automatic t_pullup();
    wr(32'h0000_0101);
    settle();
    chk32("R5 both disabled", {30'd0, pad_pullup_dis}, 32'd3);
    chk32("R5 word", rd_data, 32'h0000_2121);
    wr(32'h0000_0001);
    settle();
    chk32("R5 rewrite", {30'd0, pad_pullup_dis}, 32'd1);
    wr(32'h0000_0000);
    settle();
    chk32("R5 cleared", rd_data, 32'h0000_2020);
  endtask

  task automatic t_read_only();
    wr(32'hFFFF_2020);
    settle();
    chk32("R7 ro word", rd_data, 32'h0000_2020);
    chk32("R7 ro drive", {30'd0, pad_drive_low}, 32'd0);
  endtask

  task automatic t_sync_latency();
    @(negedge clk); ext_low = 2'b10;
    repeat (2) @(negedge clk);
    chk32("R6 not yet visible", rd_data, 32'h0000_2020);
    @(negedge clk);
    chk32("R6 visible third edge", rd_data, 32'h0000_0020);
    ext_low = 2'b00; settle();
    chk32("R6 line back high", rd_data, 32'h0000_2020);
  endtask

  task automatic t_mid_reset();
    wr(32'h0000_010E);
    chk32("R9 driving before reset", {30'd0, pad_drive_low}, 32'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk32("R9 released", {30'd0, pad_drive_low}, 32'd0);
    settle();
    chk32("R9 word cleared", rd_data, 32'h0000_2020);
    chk32("R9 pullup cleared", {30'd0, pad_pullup_dis}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_drive_clock_low();
    t_no_enable();
    t_value_path();
    t_pullup();
    t_read_only();
    t_sync_latency();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule